// File: doc/BRIEF.md
# Extended-Range Degamma Lookup Stage

This block linearizes pixel channel values before a color conversion matrix. Each incoming channel sample is an unsigned fixed-point number with 3 integer and 16 fractional bits. The block maps the sample through a 35-point table using piecewise-linear interpolation. Thirty-two equal segments cover the span from 0 to 1.0. Two wider segments cover 1.0 to 3.0 and 3.0 to 7.0. Inputs at or above 7.0 clamp to the last point.

Software programs the table through a small register port. The port has three registers: a pointer register with an auto-advance flag, a data window, and a control register. A second control bit is passed straight out to enable a later gamma stage. Table writes go into a shadow copy. A frame-start strobe copies the shadow into the working table, so a frame never uses a half-written curve.

Top module: `degamma_lut`

## Requirements
- R1: After reset the working and shadow tables hold the identity curve: entry i = i*0x800 for i in 0..32, entry 33 = 0x30000, entry 34 = 0x70000. The control register, pointer and auto flag are all 0, and pix_valid_out is 0.
- R2: pix_valid_out is pix_valid_in delayed by exactly one clock, and pix_out is updated in that same cycle.
- R3: When control bit 31 is 0, pix_out equals the accepted pix_in, with the same one-cycle latency.
- R4: When bit 31 is 1 and the input x is below 0x10000, let k = x[15:11] and f = x[10:0]. The output is t[k] + floor((t[k+1]-t[k])*f/2048).
- R5: For 0x10000 <= x < 0x30000 the output interpolates between t[32] and t[33] over a width of 0x20000. For 0x30000 <= x < 0x70000 it interpolates between t[33] and t[34] over a width of 0x40000. For x >= 0x70000 the output is t[34]. Rounding is floor in both ranges.
- R6: reg_sel selects the register: 0 is the pointer (bits 5:0 pointer, bit 15 auto flag), 1 is the table data (bits 18:0), 2 is control (bit 31 degamma enable, bit 30 post gamma enable), and 3 reads as 0. post_gamma_en follows control bit 30. Each read returns its value in reg_rdata on the clock after reg_rd.
- R7: While the auto flag is set, each data write or read advances the pointer by one. The pointer stops at 35. A data write at pointer 35 is ignored, and a data read there returns 0.
- R8: A pointer write with bit 15 clear clears the auto flag and leaves the pointer unchanged. A pointer write with bit 15 set while the flag is clear sets the flag and loads the pointer, clamped to 35. A pointer write with bit 15 set while the flag is already set has no effect.
- R9: Data writes go to the shadow table, and data reads return the shadow table. Pixels use the working table, which copies the whole shadow table on the clock after frame_start is high.
- R10: While the auto flag is clear, repeated data accesses all use the same entry and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| frame_start | input | 1 | Frame boundary strobe; copies shadow table to working table |
| pix_valid_in | input | 1 | Input sample valid |
| pix_in | input | 19 | Input sample, 3.16 unsigned |
| pix_valid_out | output | 1 | Output sample valid |
| pix_out | output | 19 | Output sample, 3.16 unsigned |
| post_gamma_en | output | 1 | Enable for the following gamma stage |

## Verification
The mapping is driven with the identity table and then with a non-monotonic table. Checking points on both sides of every kind of breakpoint tells the fine segments apart from the two wide extended segments and from the clamp region. The falling segments of the non-monotonic table show whether negative slopes round down rather than toward zero. A midpoint sample taken before the frame strobe, and again after it, shows whether shadow writes leak into the working table. Pointer sequences that stop at the end, ignore repositioning while advancing, and hold still in manual mode separate the three pointer-update rules.

// File: rtl/degamma_lut.sv
module degamma_lut #(
  parameter int FRAC   = 16,
  parameter int SEG_LG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              frame_start,
  input  logic              pix_valid_in,
  input  logic [FRAC+2:0]   pix_in,
  output logic              pix_valid_out,
  output logic [FRAC+2:0]   pix_out,
  output logic              post_gamma_en
);
  localparam int DW     = FRAC + 3;
  localparam int NSEG   = 1 << SEG_LG;
  localparam int NENT   = NSEG + 3;
  localparam int IW     = $clog2(NENT + 1);
  localparam int SEGW   = FRAC - SEG_LG;
  localparam int AUTO_B = 15;
  localparam logic [DW-1:0] X1 = DW'(1 << FRAC);
  localparam logic [DW-1:0] X3 = DW'(3 << FRAC);
  localparam logic [DW-1:0] X7 = DW'(7 << FRAC);
  localparam logic [IW-1:0] PEND = IW'(NENT);

  function automatic logic [DW-1:0] lin(int i);
    if (i <= NSEG) return DW'(i << SEGW);
    else if (i == NSEG + 1) return X3;
    else return X7;
  endfunction

  logic [DW-1:0] shadow [NENT];
  logic [DW-1:0] active [NENT];
  logic [IW-1:0] idx;
  logic          auto_inc, deg_en;

  wire sel_idx  = reg_sel == 2'd0;
  wire sel_dat  = reg_sel == 2'd1;
  wire sel_mode = reg_sel == 2'd2;
  wire in_range = idx < PEND;
  wire dat_acc  = (reg_wr || reg_rd) && sel_dat;
  wire [IW-1:0] idx_req = (reg_wdata[IW-1:0] > PEND) ? PEND : reg_wdata[IW-1:0];
  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[29:AUTO_B+1], reg_wdata[AUTO_B-1:DW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      auto_inc <= 1'b0;
      deg_en <= 1'b0;
      post_gamma_en <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && sel_idx) begin
        if (!reg_wdata[AUTO_B]) auto_inc <= 1'b0;
        else if (!auto_inc) begin
          auto_inc <= 1'b1;
          idx <= idx_req;
        end
      end else if (dat_acc && auto_inc && in_range) begin
        idx <= idx + 1'b1;
      end
      if (reg_wr && sel_mode) begin
        deg_en <= reg_wdata[31];
        post_gamma_en <= reg_wdata[30];
      end
      if (reg_rd) begin
        case (reg_sel)
          2'd0:    reg_rdata <= 32'({auto_inc, {(AUTO_B-IW){1'b0}}, idx});
          2'd1:    reg_rdata <= in_range ? 32'(shadow[idx]) : 32'd0;
          2'd2:    reg_rdata <= {deg_en, post_gamma_en, 30'd0};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        shadow[i] <= lin(i);
        active[i] <= lin(i);
      end
    end else begin
      if (reg_wr && sel_dat && in_range) shadow[idx] <= reg_wdata[DW-1:0];
      if (frame_start)
        for (int i = 0; i < NENT; i++) active[i] <= shadow[i];
    end
  end

  logic [IW-1:0] lo_i, hi_i;
  logic [DW-1:0] fr;
  logic [5:0]    sh;

  always_comb begin
    if (pix_in >= X7) begin
      lo_i = IW'(NENT - 1); hi_i = IW'(NENT - 1); fr = '0; sh = 6'(SEGW);
    end else if (pix_in >= X3) begin
      lo_i = IW'(NENT - 2); hi_i = IW'(NENT - 1); fr = pix_in - X3; sh = 6'(FRAC + 2);
    end else if (pix_in >= X1) begin
      lo_i = IW'(NSEG); hi_i = IW'(NSEG + 1); fr = pix_in - X1; sh = 6'(FRAC + 1);
    end else begin
      lo_i = IW'(pix_in[FRAC-1 -: SEG_LG]);
      hi_i = lo_i + 1'b1;
      fr = DW'(pix_in[SEGW-1:0]);
      sh = 6'(SEGW);
    end
  end

  wire [DW-1:0]          a_v    = active[lo_i];
  wire [DW-1:0]          b_v    = active[hi_i];
  wire signed [DW:0]     diff   = $signed({1'b0, b_v}) - $signed({1'b0, a_v});
  wire signed [2*DW+1:0] diff_x = {{(DW+1){diff[DW]}}, diff};
  wire signed [2*DW+1:0] fr_x   = {{(DW+2){1'b0}}, fr};
  wire signed [2*DW+1:0] prod   = diff_x * fr_x;
  wire [DW-1:0]          interp = a_v + DW'(prod >>> sh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid_out <= 1'b0;
      pix_out <= '0;
    end else begin
      pix_valid_out <= pix_valid_in;
      if (pix_valid_in) pix_out <= deg_en ? interp : pix_in;
    end
  end
endmodule

// File: rtl/degamma_lut_chk.sv
module degamma_lut_chk #(
  parameter int FRAC = 16,
  parameter int IW   = 6,
  parameter int NENT = 35
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pix_valid_in,
  input logic [FRAC+2:0] pix_in,
  input logic            pix_valid_out,
  input logic [FRAC+2:0] pix_out,
  input logic            reg_wr,
  input logic [1:0]      reg_sel,
  input logic            post_gamma_en,
  input logic            frame_start,
  input logic            deg_en,
  input logic [IW-1:0]   idx,
  input logic [FRAC+2:0] act_top
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_in |=> pix_valid_out);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_in |=> !pix_valid_out);
  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_in && !deg_en) |=> (pix_out == $past(pix_in)));
  // R5
  clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_in && deg_en && pix_in >= (FRAC+3)'(7 << FRAC)) |=> (pix_out == $past(act_top)));
  // R7
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(NENT));
  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_top));
  // R6
  post_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel == 2'd2) |=> $stable(post_gamma_en));
endmodule

bind degamma_lut degamma_lut_chk #(.FRAC(FRAC), .IW(IW), .NENT(NENT)) u_degamma_lut_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid_in(pix_valid_in), .pix_in(pix_in),
  .pix_valid_out(pix_valid_out), .pix_out(pix_out), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .post_gamma_en(post_gamma_en), .frame_start(frame_start), .deg_en(deg_en), .idx(idx),
  .act_top(active[NENT-1])
);

// File: tb/test_degamma_lut.sv
module test_degamma_lut;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_start = 1'b0;
  logic        pix_valid_in = 1'b0;
  logic [18:0] pix_in = '0;
  logic        pix_valid_out;
  logic [18:0] pix_out;
  logic        post_gamma_en;

  degamma_lut i_degamma_lut (.*);

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0;
  longint shadow_m [35];
  longint active_m [35];
  int     idx_m = 0;
  bit     auto_m = 0, deg_m = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  function automatic longint model(input longint x);
    longint a, b, f, w, num, q;
    if (x >= 'h70000) return active_m[34];
    if (x >= 'h30000) begin a = active_m[33]; b = active_m[34]; f = x - 'h30000; w = 'h40000; end
    else if (x >= 'h10000) begin a = active_m[32]; b = active_m[33]; f = x - 'h10000; w = 'h20000; end
    else begin a = active_m[x / 2048]; b = active_m[x / 2048 + 1]; f = x % 2048; w = 2048; end
    num = (b - a) * f;
    if (num < 0) q = -((-num + w - 1) / w); else q = num / w;
    return a + q;
  endfunction

  function automatic longint tval(input int i);
    return longint'(((i * 32'h2345) ^ (i << 13)) & 32'h7FFFF);
  endfunction

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    if (s == 2'd0) begin
      if (!v[15]) auto_m = 0;
      else if (!auto_m) begin auto_m = 1; idx_m = (v[5:0] > 35) ? 35 : int'(v[5:0]); end
    end else if (s == 2'd1) begin
      if (idx_m < 35) shadow_m[idx_m] = longint'(v[18:0]);
      if (auto_m && idx_m < 35) idx_m++;
    end else if (s == 2'd2) deg_m = v[31];
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = s;
    @(posedge clk); #1;
    v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic rd_dat(input string r);
    logic [31:0] v;
    longint e;
    e = (idx_m < 35) ? shadow_m[idx_m] : 0;
    rd(2'd1, v);
    chk(r, v, 32'(e));
    if (auto_m && idx_m < 35) idx_m++;
  endtask

  task automatic rd_idx(input string r);
    logic [31:0] v;
    rd(2'd0, v);
    chk(r, v, {16'd0, auto_m, 9'd0, 6'(idx_m)});
  endtask

  task automatic px(input logic [18:0] x, input string r);
    longint e;
    e = deg_m ? model(longint'(x)) : longint'(x);
    @(negedge clk);
    pix_valid_in = 1'b1; pix_in = x;
    @(posedge clk); #1;
    chk(r, 32'(pix_out), 32'(e));
    chk("R2 valid", 32'(pix_valid_out), 32'd1);
    pix_valid_in = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int i = 0; i < 35; i++) active_m[i] = shadow_m[i];
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 valid_out", 32'(pix_valid_out), 32'd0);
    chk("R1 post_en", 32'(post_gamma_en), 32'd0);
    rd(2'd2, v); chk("R1 mode", v, 32'd0);
    rd_idx("R1 pointer");
    rd(2'd3, v); chk("R6 sel3", v, 32'd0);
    rd_dat("R1 entry0");
  endtask

  task automatic t_bypass();
    px(19'h12345, "R3 bypass");
    px(19'h7FFFF, "R3 bypass max");
    px(19'h00000, "R3 bypass zero");
    @(posedge clk); #1;
    chk("R2 idle", 32'(pix_valid_out), 32'd0);
  endtask

  task automatic t_identity();
    wr(2'd2, 32'h8000_0000);
    px(19'h00000, "R4 id"); px(19'h00800, "R4 id"); px(19'h00ABC, "R4 id");
    px(19'h0FFFF, "R4 id"); px(19'h10000, "R5 id"); px(19'h1F00F, "R5 id");
    px(19'h30000, "R5 id"); px(19'h5A5A5, "R5 id"); px(19'h6FFFF, "R5 id");
    px(19'h70000, "R5 clamp"); px(19'h7FFFF, "R5 clamp");
  endtask

  task automatic t_load();
    wr(2'd0, 32'h0); wr(2'd0, 32'h8000);
    for (int i = 0; i < 35; i++) wr(2'd1, 32'(tval(i)));
    px(19'h04321, "R9 before frame");
    frame();
    px(19'h00000, "R4 custom"); px(19'h007FF, "R4 custom"); px(19'h00801, "R4 custom");
    px(19'h03456, "R4 custom"); px(19'h08000, "R4 custom"); px(19'h0F801, "R4 custom");
    px(19'h0FFFF, "R4 custom"); px(19'h10000, "R5 custom"); px(19'h18000, "R5 custom");
    px(19'h2FFFF, "R5 custom"); px(19'h30000, "R5 custom"); px(19'h4ABCD, "R5 custom");
    px(19'h6FFFF, "R5 custom"); px(19'h70000, "R5 custom"); px(19'h7FFFF, "R5 custom");
  endtask

  task automatic t_readback();
    wr(2'd0, 32'h0); wr(2'd0, 32'h8000);
    for (int i = 0; i < 35; i++) rd_dat("R9 readback");
    rd_idx("R7 stop at 35");
    rd_dat("R7 read past end");
    rd_idx("R7 still 35");
    wr(2'd1, 32'h5_5555);
  endtask

  task automatic t_pointer();
    wr(2'd0, 32'h8005);
    rd_idx("R8 ignored while auto");
    wr(2'd0, 32'h0005);
    rd_idx("R8 clear keeps pointer");
    wr(2'd0, 32'h8028);
    rd_idx("R8 clamp");
    wr(2'd0, 32'h0); wr(2'd0, 32'h8022);
    rd_dat("R7 write past end ignored");
    rd_idx("R7 advance");
  endtask

  task automatic t_manual();
    wr(2'd0, 32'h0); wr(2'd0, 32'h8003);
    wr(2'd1, 32'h1_1111);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h2_2222);
    wr(2'd1, 32'h2_4444);
    rd_idx("R10 no advance");
    rd_dat("R10 same entry");
    rd_dat("R10 same entry again");
    rd_idx("R10 read no advance");
    frame();
    px(19'h01C00, "R4 manual seg");
    px(19'h02400, "R4 manual seg");
  endtask

  task automatic t_mode();
    logic [31:0] v;
    wr(2'd2, 32'h4000_0000);
    chk("R6 post_en", 32'(post_gamma_en), 32'd1);
    rd(2'd2, v); chk("R6 mode read", v, 32'h4000_0000);
    px(19'h01C00, "R3 bypass after disable");
    wr(2'd2, 32'hC000_0000);
    rd(2'd2, v); chk("R6 mode both", v, 32'hC000_0000);
    px(19'h01C00, "R4 re-enabled");
  endtask

  initial begin
    for (int i = 0; i < 35; i++) begin
      shadow_m[i] = (i <= 32) ? longint'(i) * 'h800 : (i == 33 ? 'h30000 : 'h70000);
      active_m[i] = shadow_m[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_bypass();
    t_identity();
    t_load();
    t_readback();
    t_pointer();
    t_manual();
    t_mode();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule